// File: doc/BRIEF.md
# Interrupt Aggregation and Masking Controller

This block gathers interrupt events from a set of hardware sources into a vector of pending bits, one bit per source. Each source's bit is set on a rising edge of its input. A host CPU reaches the block through a small single-cycle register port. Through that port it can read the pending bits either unfiltered or filtered by a per-source enable mask. It can also raise any interrupt from software, clear serviced interrupts, and turn sources on or off through separate write-one-to-set and write-one-to-clear enable registers.

The block drives one interrupt line to the CPU. In level mode the line stays high while any enabled interrupt is pending. In pulse mode the line gives a single one-cycle pulse and then stays quiet until the CPU writes the end-of-service address. That write re-arms the output, so interrupts that are still enabled and pending produce a fresh pulse.

Top module: `irq_agg_ctrl`

## Requirements
- R1: After reset, all pending bits and all enable bits are zero, the output mode is level, and `irq_o` is low.
- R2: A rising edge on `src_i[N]` sets pending bit N one clock later. An input held high does not set the bit again after software has cleared it.
- R3: A read at offset 0x58 returns all pending bits, whatever the enable mask holds. Writing 1 to a bit at 0x58 sets that pending bit. Writing 0 leaves the bit unchanged.
- R4: A read at offset 0x5C returns the pending bits ANDed with the enable bits. Writing 1 to a bit at 0x5C clears that pending bit. If a hardware rising edge lands on the same bit in the same cycle, the bit stays set.
- R5: Writing 1 to a bit at offset 0x60 enables that source, and writing 1 to a bit at offset 0x64 disables it. Zero bits leave the enable unchanged. A read at either offset returns the current enable mask.
- R6: In level mode, `irq_o` equals the OR of all pending-and-enabled bits, with no added delay.
- R7: Bit 0 at offset 0x6C selects the output mode: 0 for level, 1 for pulse. A read at that offset returns the mode in bit 0.
- R8: In pulse mode, `irq_o` goes high for exactly one cycle when the output is armed and an enabled interrupt is pending. It then stays low until the next end-of-service write.
- R9: A write to offset 0x68 re-arms the pulse output. If an enabled interrupt is still pending, a pulse appears in the cycle right after the write. A read at 0x68 returns zero.
- R10: A read at any other offset returns zero. A write to any other offset changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_i | input | N_SRC | Hardware interrupt source lines |
| bus_wr | input | 1 | Register write strobe, one cycle per write |
| bus_addr | input | 8 | Register byte offset |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for `bus_addr`, combinational |
| irq_o | output | 1 | Interrupt line to the CPU |

## Verification
The assertions check several rules on every cycle:
- pending bits are sticky except for an explicit clear;
- a rising edge on a source always shows up as a pending bit;
- the level output tracks the masked OR;
- a pulse never lasts longer than one cycle unless an end-of-service write intervened;
- the output is never high without an enabled pending interrupt;
- the end-of-service offset reads as zero.

Other behaviour depends on register sequences and only the bench scenarios can show it. This covers the full sweep of enable and pending patterns on both status reads, the hardware-over-software priority in a colliding cycle, the silence between pulses, the re-pulse after an end-of-service write, and unmapped offsets leaving state untouched.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;

    localparam int REG_ADDR_W = 8;

    typedef enum logic [REG_ADDR_W-1:0] {
        OFF_RAW  = 8'h58,
        OFF_MSK  = 8'h5C,
        OFF_ENS  = 8'h60,
        OFF_ENC  = 8'h64,
        OFF_EOI  = 8'h68,
        OFF_MODE = 8'h6C
    } reg_off_e;

    typedef enum logic {
        MODE_LEVEL = 1'b0,
        MODE_PULSE = 1'b1
    } out_mode_e;

    typedef struct packed {
        logic sw_set;
        logic sw_clr;
        logic en_set;
        logic en_clr;
        logic eoi;
        logic mode_wr;
    } wr_strobe_t;

    function automatic wr_strobe_t decode_write(input logic wr,
                                                input logic [REG_ADDR_W-1:0] addr);
        wr_strobe_t s;
        s = '0;
        if (wr) begin
            case (addr)
                OFF_RAW:  s.sw_set  = 1'b1;
                OFF_MSK:  s.sw_clr  = 1'b1;
                OFF_ENS:  s.en_set  = 1'b1;
                OFF_ENC:  s.en_clr  = 1'b1;
                OFF_EOI:  s.eoi     = 1'b1;
                OFF_MODE: s.mode_wr = 1'b1;
                default:  s = '0;
            endcase
        end
        return s;
    endfunction

endpackage

// File: rtl/irq_edge_detect.sv
module irq_edge_detect #(
    parameter int N_SRC = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [N_SRC-1:0] src_i,
    output logic [N_SRC-1:0] rise_o
);
    logic [N_SRC-1:0] prev_q;

    for (genvar i = 0; i < N_SRC; i++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst) prev_q[i] <= 1'b0;
            else     prev_q[i] <= src_i[i];
        end
        assign rise_o[i] = src_i[i] & ~prev_q[i];
    end
endmodule

// File: rtl/irq_pending_bank.sv
module irq_pending_bank #(
    parameter int N_SRC = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [N_SRC-1:0] hw_rise,
    input  logic [N_SRC-1:0] set_vec,
    input  logic [N_SRC-1:0] clr_vec,
    input  logic [N_SRC-1:0] en_set_vec,
    input  logic [N_SRC-1:0] en_clr_vec,
    output logic [N_SRC-1:0] pend_o,
    output logic [N_SRC-1:0] en_o
);
    for (genvar i = 0; i < N_SRC; i++) begin : g_bit
        // a hardware edge overrides a same-cycle software clear
        always_ff @(posedge clk) begin
            if (rst)                          pend_o[i] <= 1'b0;
            else if (hw_rise[i] | set_vec[i]) pend_o[i] <= 1'b1;
            else if (clr_vec[i])              pend_o[i] <= 1'b0;
        end

        always_ff @(posedge clk) begin
            if (rst)                en_o[i] <= 1'b0;
            else if (en_set_vec[i]) en_o[i] <= 1'b1;
            else if (en_clr_vec[i]) en_o[i] <= 1'b0;
        end
    end
endmodule

// File: rtl/irq_out_gen.sv
module irq_out_gen
    import irq_agg_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      any_i,
    input  logic      eoi_i,
    input  logic      mode_wr_i,
    input  logic      mode_d_i,
    output out_mode_e mode_o,
    output logic      irq_o
);
    logic armed_q;
    logic fire;

    assign fire  = (mode_o == MODE_PULSE) & armed_q & any_i;
    assign irq_o = (mode_o == MODE_PULSE) ? fire : any_i;

    always_ff @(posedge clk) begin
        if (rst)            mode_o <= MODE_LEVEL;
        else if (mode_wr_i) mode_o <= out_mode_e'(mode_d_i);
    end

    // end-of-service re-arms; a pulse disarms until then
    always_ff @(posedge clk) begin
        if (rst)        armed_q <= 1'b1;
        else if (eoi_i) armed_q <= 1'b1;
        else if (fire)  armed_q <= 1'b0;
    end
endmodule

// File: rtl/irq_agg_ctrl.sv
module irq_agg_ctrl
    import irq_agg_pkg::*;
#(
    parameter int N_SRC  = 8,
    parameter int DATA_W = 32
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [N_SRC-1:0]      src_i,
    input  logic                  bus_wr,
    input  logic [REG_ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0]     bus_wdata,
    output logic [DATA_W-1:0]     bus_rdata,
    output logic                  irq_o
);
    wr_strobe_t       stb;
    logic [N_SRC-1:0] wvec;
    logic [N_SRC-1:0] hw_rise;
    logic [N_SRC-1:0] pend_q;
    logic [N_SRC-1:0] en_q;
    logic [N_SRC-1:0] masked;
    out_mode_e        mode_q;

    assign stb    = decode_write(bus_wr, bus_addr);
    assign wvec   = bus_wdata[N_SRC-1:0];
    assign masked = pend_q & en_q;

    irq_edge_detect #(.N_SRC(N_SRC)) u_edge (
        .clk    (clk),
        .rst    (rst),
        .src_i  (src_i),
        .rise_o (hw_rise)
    );

    irq_pending_bank #(.N_SRC(N_SRC)) u_bank (
        .clk        (clk),
        .rst        (rst),
        .hw_rise    (hw_rise),
        .set_vec    (stb.sw_set ? wvec : '0),
        .clr_vec    (stb.sw_clr ? wvec : '0),
        .en_set_vec (stb.en_set ? wvec : '0),
        .en_clr_vec (stb.en_clr ? wvec : '0),
        .pend_o     (pend_q),
        .en_o       (en_q)
    );

    irq_out_gen u_out (
        .clk       (clk),
        .rst       (rst),
        .any_i     (|masked),
        .eoi_i     (stb.eoi),
        .mode_wr_i (stb.mode_wr),
        .mode_d_i  (bus_wdata[0]),
        .mode_o    (mode_q),
        .irq_o     (irq_o)
    );

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            OFF_RAW:          bus_rdata[N_SRC-1:0] = pend_q;
            OFF_MSK:          bus_rdata[N_SRC-1:0] = masked;
            OFF_ENS, OFF_ENC: bus_rdata[N_SRC-1:0] = en_q;
            OFF_MODE:         bus_rdata[0]         = mode_q;
            default:          bus_rdata            = '0;
        endcase
    end
endmodule

// File: rtl/irq_agg_chk.sv
module irq_agg_chk
    import irq_agg_pkg::*;
#(
    parameter int N_SRC  = 8,
    parameter int DATA_W = 32
) (
    input logic                  clk,
    input logic                  rst,
    input logic [N_SRC-1:0]      src_i,
    input logic                  bus_wr,
    input logic [REG_ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0]     bus_wdata,
    input logic [DATA_W-1:0]     bus_rdata,
    input logic                  irq_o,
    input logic [N_SRC-1:0]      pend,
    input logic [N_SRC-1:0]      en,
    input logic                  mode
);
    logic [N_SRC-1:0] clr_req;
    logic             eoi_req;

    assign clr_req = (bus_wr && bus_addr == OFF_MSK) ? bus_wdata[N_SRC-1:0] : '0;
    assign eoi_req = bus_wr && bus_addr == OFF_EOI;

    AST_PEND_STICKY: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (($past(pend) & ~$past(clr_req) & ~pend) == '0)); // R4

    AST_HW_EDGE_SETS: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (($past(src_i) & ~$past(src_i, 2) & ~pend) == '0)); // R2

    AST_LEVEL_TRACKS: assert property (@(posedge clk) disable iff (rst)
        !mode |-> (irq_o == |(pend & en))); // R6

    AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && mode && $past(mode) && $past(irq_o) && !$past(eoi_req)) |-> !irq_o); // R8

    AST_NO_SPURIOUS_IRQ: assert property (@(posedge clk) disable iff (rst)
        irq_o |-> |(pend & en)); // R8

    AST_EOI_READS_ZERO: assert property (@(posedge clk) disable iff (rst)
        (bus_addr == OFF_EOI) |-> (bus_rdata == '0)); // R9
endmodule

bind irq_agg_ctrl irq_agg_chk #(.N_SRC(N_SRC), .DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .src_i     (src_i),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .irq_o     (irq_o),
    .pend      (pend_q),
    .en        (en_q),
    .mode      (mode_q)
);

// File: tb/irq_agg_ctrl_tb.sv
module irq_agg_ctrl_tb;
    localparam int NS = 4;
    localparam int DW = 32;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [NS-1:0] src_i = '0;
    logic          bus_wr = 1'b0;
    logic [7:0]    bus_addr = '0;
    logic [DW-1:0] bus_wdata = '0;
    logic [DW-1:0] bus_rdata;
    logic          irq_o;

    int n_chk = 0;
    int n_err = 0;

    always #5 clk = ~clk;

    irq_agg_ctrl #(.N_SRC(NS), .DATA_W(DW)) u_dut (
        .clk       (clk),
        .rst       (rst),
        .src_i     (src_i),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq_o     (irq_o)
    );

    task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [DW-1:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0; bus_addr = 8'h00; bus_wdata = '0;
        #1;
    endtask

    task automatic rd(input logic [7:0] a, output logic [DW-1:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
        bus_addr = 8'h00;
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [DW-1:0] r;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        // R1 reset state
        rd(8'h58, r); check("R1 raw", r, 0);
        rd(8'h60, r); check("R1 enable", r, 0);
        rd(8'h6C, r); check("R1 mode", r, 0);
        check("R1 irq", irq_o, 0);

        // R3 R4 R5 R6 sweep of enable and pending patterns in level mode
        for (int e = 0; e < 16; e++) begin
            for (int p = 0; p < 16; p++) begin
                wr(8'h64, 32'hF);
                wr(8'h60, e);
                wr(8'h5C, 32'hF);
                wr(8'h58, p);
                rd(8'h58, r); check("R3 raw read", r, p);
                rd(8'h5C, r); check("R4 masked read", r, p & e);
                rd(8'h64, r); check("R5 enable read", r, e);
                check("R6 level irq", irq_o, ((p & e) != 0));
            end
        end

        // R3 zero bits have no effect on pending
        wr(8'h5C, 32'hF); wr(8'h58, 32'h5); wr(8'h58, 32'h0);
        rd(8'h58, r); check("R3 zero write", r, 32'h5);
        // R5 zero bits have no effect on enables
        wr(8'h64, 32'hF); wr(8'h60, 32'h5); wr(8'h60, 32'h0); wr(8'h64, 32'h0);
        rd(8'h60, r); check("R5 zero write", r, 32'h5);
        wr(8'h64, 32'h1);
        rd(8'h60, r); check("R5 clear one", r, 32'h4);

        // R10 unmapped offset
        wr(8'h70, 32'hFFFF_FFFF);
        rd(8'h70, r); check("R10 read zero", r, 0);
        rd(8'h58, r); check("R10 pending kept", r, 32'h5);
        rd(8'h60, r); check("R10 enable kept", r, 32'h4);

        // R2 hardware rising edge, one cycle latency
        wr(8'h5C, 32'hF);
        @(negedge clk); src_i[2] = 1'b1;
        #1; rd(8'h58, r); check("R2 before edge", r, 0);
        @(negedge clk); #1;
        rd(8'h58, r); check("R2 edge sets", r, 32'h4);
        check("R6 irq on edge", irq_o, 1);
        wr(8'h5C, 32'h4);
        rd(8'h58, r); check("R2 held high no reset", r, 0);
        @(negedge clk); src_i[2] = 1'b0;

        // R4 hardware edge wins over same-cycle clear
        wr(8'h58, 32'h2);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = 8'h5C; bus_wdata = 32'h2; src_i[1] = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; bus_addr = 8'h00; bus_wdata = '0;
        #1; rd(8'h58, r); check("R4 hw wins", r, 32'h2);
        wr(8'h5C, 32'h2);
        rd(8'h58, r); check("R4 clear after", r, 0);
        @(negedge clk); src_i[1] = 1'b0;

        // R7 pulse mode select
        wr(8'h64, 32'hF); wr(8'h60, 32'h1);
        wr(8'h6C, 32'h1);
        rd(8'h6C, r); check("R7 mode read", r, 1);
        check("R8 idle", irq_o, 0);

        // R8 single pulse
        @(negedge clk); src_i[0] = 1'b1;
        @(negedge clk); #1;
        check("R8 pulse high", irq_o, 1);
        @(negedge clk); #1;
        check("R8 pulse ends", irq_o, 0);
        wr(8'h58, 32'h8);
        check("R8 no repeat", irq_o, 0);
        // R9 end-of-service re-pulses while pending
        rd(8'h68, r); check("R9 eoi reads zero", r, 0);
        wr(8'h68, 32'h0);
        check("R9 re-pulse", irq_o, 1);
        @(negedge clk); #1;
        check("R9 re-pulse single", irq_o, 0);
        // R9 no pulse after service complete
        wr(8'h5C, 32'hF);
        wr(8'h68, 32'h0);
        check("R9 no pending no pulse", irq_o, 0);
        @(negedge clk); #1;
        check("R9 stays low", irq_o, 0);
        // R8 armed: next rising edge fires immediately
        @(negedge clk); src_i[0] = 1'b0;
        @(negedge clk); src_i[0] = 1'b1;
        @(negedge clk); #1;
        check("R8 armed edge pulse", irq_o, 1);

        // R7 back to level
        wr(8'h6C, 32'h0);
        rd(8'h6C, r); check("R7 level read", r, 0);
        check("R6 level again", irq_o, 1);

        finish_run();
    end
endmodule